// File: doc/BRIEF.md
# Time-Shared Multiply-Accumulate FIR Filter

This block is a finite impulse response filter built on a fixed pool of sixteen multiply-accumulate units. Each unit can be stepped across one, two, four or eight system-clock cycles per sample, so the filter length grows from 16 to 128 taps. As the length grows, the highest sample rate drops by the same factor. Samples and coefficients are 16-bit two's complement values. Each coefficient is cut down to 12 bits when it is written. Products are summed at 32 bits and the result leaves the block unscaled. A 32-bit cascade word, given together with the sample that starts a computation, is added to the primary result, so several blocks can be chained.

Two configuration bits change how the pool is used. One splits the pool into two independent filters of half length, each with its own sample input and result output. The other turns on decimation by two. In that mode only every second accepted sample produces a result, and samples may arrive twice as often for a given tap count. A host loads the coefficient store through a simple write port while the filter is idle, and it may reload the store at any later idle time. Mode, split and decimate settings are expected to change only across a reset.

Top module: `fir_mac_array`

## Requirements
- R1: With split off and decimate off, tap count is 16·2^mode (mode_i 0..3). Each result is y_a_o = Σ_{t<T} c[t]·x[n−t] + cascade, where x[n] is the triggering sample, c[t] is coefficient address t, and samples before reset count as zero.
- R2: After an accepted sample, sample_en_i is ignored for S−1 cycles and busy_o is 1 during those cycles. S is 2^mode with decimate off and max(1, 2^mode/2) with decimate on. An ignored strobe does not enter the sample history.
- R3: A coefficient written as a 16-bit word is used as its upper 12 bits (bits 15:4) taken as a signed value. Bits 3:0 have no effect.
- R4: Products are sign-extended and summed modulo 2^32 with no saturation or rescaling.
- R5: cascade_i, sampled in the cycle that the triggering sample is accepted, is added to y_a_o and never to y_b_o.
- R6: With split_i = 1 there are two filters of 8·2^mode taps. Filter A takes x_a_i and coefficient addresses t. Filter B takes x_b_i and coefficient addresses 64+t, and its result appears on y_b_o. With split_i = 0, y_b_o is 0.
- R7: With dec_i = 1, only every second accepted sample after reset triggers a result (the 2nd, 4th, …). The result sums over the full history ending at that sample.
- R8: valid_o pulses for one cycle per result, 2^mode + 2 cycles after the cycle in which the triggering sample was accepted. y_a_o and y_b_o hold their value until the next result.
- R9: A write with coef_we_i = 1 stores into address coef_addr_i on the next edge. A reload changes later results without a reset.
- R10: After reset, valid_o, busy_o, y_a_o and y_b_o are 0, and the sample history and coefficients are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Tap-count select (16·2^mode taps) |
| split_i | input | 1 | Two half-length filters when 1 |
| dec_i | input | 1 | Decimate-by-two when 1 |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_addr_i | input | 7 | Coefficient write address |
| coef_data_i | input | 16 | Coefficient write value |
| sample_en_i | input | 1 | New sample offered this cycle |
| x_a_i | input | 16 | Sample for filter A (or the single filter) |
| x_b_i | input | 16 | Sample for filter B in split mode |
| cascade_i | input | 32 | Partial sum from a preceding block |
| busy_o | output | 1 | A strobe this cycle would be ignored |
| valid_o | output | 1 | One-cycle result strobe |
| y_a_o | output | 32 | Result of filter A (or the single filter) |
| y_b_o | output | 32 | Result of filter B in split mode |

## Verification
The bench drives strobes at exactly the minimum spacing of every mode. A sequencer that accepted too early would shift an extra sample into the history, and one that started the next run late would drop or delay results. A strobe is forced into a busy cycle with a junk value; if it were accepted, every later sum would be displaced. Decimation at four and eight cycles per run moves the history during a computation, so an index that does not follow the shift reads neighbours one tap off. A full-scale pattern wraps the accumulators, and coefficients with only low bits set expose a wrong truncation point. Split runs with different streams catch swapped coefficient banks and cascade leaking into the second output.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam int NMAC = 16;            // multiply-accumulate units
  localparam int DW   = 16;            // sample width
  localparam int CWI  = 16;            // coefficient width at the port
  localparam int CW   = 12;            // stored coefficient width
  localparam int AW   = 32;            // accumulator width
  localparam int MAXR = 8;             // largest cycles-per-sample
  localparam int MW   = $clog2(MAXR) > 0 ? 2 : 1;
  localparam int KW   = $clog2(MAXR);
  localparam int NTAP = NMAC * MAXR;
  localparam int CAW  = $clog2(NTAP);
  localparam int LINE = NTAP / 2 + 1;  // one spare entry per line for mid-run shifts
  localparam int HLEN = 2 * LINE;
  localparam int HIW  = $clog2(HLEN);
endpackage

// File: rtl/fir_ctrl.sv
module fir_ctrl #(
  parameter int MW = fir_pkg::MW,
  parameter int KW = fir_pkg::KW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sample_en_i,
  input  logic [MW-1:0] mode_i,
  input  logic          dec_i,
  output logic          accept_o,
  output logic          start_o,
  output logic          run_o,
  output logic [KW-1:0] k_o,
  output logic          off_o,
  output logic          last_o,
  output logic          done_o,
  output logic          busy_o
);
  logic [KW:0]   rate;
  logic [KW-1:0] rlast, gap_init, gap_q, k_q;
  logic          phase_q, run_q, off_q, done_q;

  assign rate     = (KW+1)'(1) << mode_i;
  assign rlast    = KW'(rate - 1'b1);
  assign gap_init = dec_i ? ((mode_i == '0) ? '0 : KW'((rate >> 1) - 1'b1)) : rlast;

  assign busy_o   = (gap_q != '0);
  assign accept_o = sample_en_i && !busy_o;
  assign start_o  = accept_o && (!dec_i || phase_q);
  assign last_o   = run_q && (k_q == rlast);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      phase_q <= 1'b0;
      run_q   <= 1'b0;
      k_q     <= '0;
      off_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      gap_q  <= accept_o ? gap_init : (busy_o ? gap_q - 1'b1 : '0);
      done_q <= last_o;
      if (accept_o) phase_q <= dec_i ? !phase_q : 1'b0;
      if (start_o) begin
        run_q <= 1'b1;
        k_q   <= '0;
        off_q <= 1'b0;
      end else if (run_q) begin
        if (last_o) run_q <= 1'b0;
        else        k_q   <= k_q + 1'b1;
        if (accept_o) off_q <= 1'b1;   // history moved under a running sum
      end
    end
  end

  assign run_o  = run_q;
  assign k_o    = k_q;
  assign off_o  = off_q;
  assign done_o = done_q;

  a_r2_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_o && gap_init != '0) |=> !accept_o);
  a_r1_k_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q |-> (k_q <= rlast));
  a_r7_off_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    off_q |-> dec_i);
  a_r8_done_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $past(run_q));
endmodule

// File: rtl/fir_hist.sv
module fir_hist #(
  parameter int DW   = fir_pkg::DW,
  parameter int LINE = fir_pkg::LINE,
  parameter int HLEN = fir_pkg::HLEN
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     shift_i,
  input  logic                     split_i,
  input  logic [DW-1:0]            in_a_i,
  input  logic [DW-1:0]            in_b_i,
  output logic [HLEN-1:0][DW-1:0]  hist_o
);
  logic [HLEN-1:0][DW-1:0] hist_q;

  for (genvar i = 0; i < HLEN; i++) begin : g_tap
    logic [DW-1:0] nxt;
    if (i == 0) begin : g_head
      assign nxt = in_a_i;
    end else if (i == LINE) begin : g_bhead
      assign nxt = split_i ? in_b_i : hist_q[i-1];
    end else begin : g_body
      assign nxt = hist_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q[i] <= '0;
      else if (shift_i) hist_q[i] <= nxt;
    end
  end

  assign hist_o = hist_q;

  a_r1_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> (hist_q[0] == $past(in_a_i)));
  a_r6_b_head: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && split_i) |=> (hist_q[LINE] == $past(in_b_i)));
endmodule

// File: rtl/fir_coef_store.sv
module fir_coef_store #(
  parameter int CWI  = fir_pkg::CWI,
  parameter int CW   = fir_pkg::CW,
  parameter int NTAP = fir_pkg::NTAP,
  parameter int CAW  = fir_pkg::CAW,
  parameter int NRD  = fir_pkg::NMAC
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [CAW-1:0]           addr_i,
  input  logic [CWI-1:0]           data_i,
  input  logic [NRD-1:0][CAW-1:0]  rd_addr_i,
  output logic [NRD-1:0][CW-1:0]   rd_data_o
);
  logic [NTAP-1:0][CW-1:0] mem_q;
  logic [CW-1:0]           wval;

  assign wval = data_i[CWI-1 -: CW];   // keep the upper bits, drop the rest

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[addr_i] <= wval;
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_addr_i[r]];
  end

  a_r3_store_upper: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (mem_q[$past(addr_i)] == $past(data_i[CWI-1 -: CW])));
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int DW = fir_pkg::DW,
  parameter int CW = fir_pkg::CW,
  parameter int AW = fir_pkg::AW
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 clr_i,
  input  logic signed [DW-1:0] x_i,
  input  logic signed [CW-1:0] c_i,
  output logic signed [AW-1:0] acc_o
);
  localparam int PW = DW + CW;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext, acc_q;

  assign prod     = x_i * c_i;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_q <= '0;
    else if (en_i) acc_q <= clr_i ? prod_ext : acc_q + prod_ext;
  end

  assign acc_o = acc_q;

  a_r4_wrap_sum: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i) |=> (acc_q == AW'($past(acc_q) + $past(prod_ext))));
endmodule

// File: rtl/fir_mac_array.sv
module fir_mac_array
  import fir_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [1:0]  mode_i,
  input  logic        split_i,
  input  logic        dec_i,
  input  logic        coef_we_i,
  input  logic [6:0]  coef_addr_i,
  input  logic [15:0] coef_data_i,
  input  logic        sample_en_i,
  input  logic [15:0] x_a_i,
  input  logic [15:0] x_b_i,
  input  logic [31:0] cascade_i,
  output logic        busy_o,
  output logic        valid_o,
  output logic [31:0] y_a_o,
  output logic [31:0] y_b_o
);
  localparam int HM = NMAC / 2;

  logic          accept, start, run, off, last, done;
  logic [KW-1:0] k;

  fir_ctrl #(.MW(2), .KW(KW)) u_ctrl (
    .clk_i, .rst_ni, .sample_en_i, .mode_i, .dec_i,
    .accept_o(accept), .start_o(start), .run_o(run), .k_o(k),
    .off_o(off), .last_o(last), .done_o(done), .busy_o(busy_o)
  );

  logic [HLEN-1:0][DW-1:0] hist;

  fir_hist #(.DW(DW), .LINE(LINE), .HLEN(HLEN)) u_hist (
    .clk_i, .rst_ni, .shift_i(accept), .split_i,
    .in_a_i(x_a_i), .in_b_i(x_b_i), .hist_o(hist)
  );

  logic [NMAC-1:0][CAW-1:0] cidx;
  logic [NMAC-1:0][CW-1:0]  coef;

  fir_coef_store #(.CWI(CWI), .CW(CW), .NTAP(NTAP), .CAW(CAW), .NRD(NMAC)) u_coef (
    .clk_i, .rst_ni, .we_i(coef_we_i), .addr_i(coef_addr_i), .data_i(coef_data_i),
    .rd_addr_i(cidx), .rd_data_o(coef)
  );

  logic signed [AW-1:0] acc [NMAC];

  for (genvar j = 0; j < NMAC; j++) begin : g_mac
    logic [HIW-1:0] hidx;
    int ci, hi;
    always_comb begin
      if (!split_i) begin
        ci = int'(k) * NMAC + j;
        hi = ci + int'(off);
      end else if (j < HM) begin
        ci = int'(k) * HM + j;
        hi = ci + int'(off);
      end else begin
        ci = NTAP / 2 + int'(k) * HM + (j - HM);
        hi = LINE + int'(k) * HM + (j - HM) + int'(off);
      end
    end
    assign cidx[j] = CAW'(ci);
    assign hidx    = HIW'(hi);

    fir_mac #(.DW(DW), .CW(CW), .AW(AW)) u_mac (
      .clk_i, .rst_ni, .en_i(run), .clr_i(k == '0),
      .x_i(hist[hidx]), .c_i(coef[j]), .acc_o(acc[j])
    );
  end

  // cascade travels with its run: captured at start, moved on at the last step
  logic [AW-1:0] casc_q, casc_out_q;
  logic [AW-1:0] sum_a, sum_b, y_a_q, y_b_q;
  logic          valid_q;

  always_comb begin
    sum_a = casc_out_q;
    sum_b = '0;
    for (int j = 0; j < NMAC; j++) begin
      if (!split_i || j < HM) sum_a = sum_a + acc[j];
      else                    sum_b = sum_b + acc[j];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      casc_q     <= '0;
      casc_out_q <= '0;
      y_a_q      <= '0;
      y_b_q      <= '0;
      valid_q    <= 1'b0;
    end else begin
      if (start) casc_q <= cascade_i;
      if (last)  casc_out_q <= casc_q;
      valid_q <= done;
      if (done) begin
        y_a_q <= sum_a;
        y_b_q <= sum_b;
      end
    end
  end

  assign valid_o = valid_q;
  assign y_a_o   = y_a_q;
  assign y_b_o   = y_b_q;

  a_r6_b_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && !split_i) |-> (y_b_q == '0));
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_q |-> ($stable(y_a_q) && $stable(y_b_q)));
  a_r5_casc_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (casc_q == $past(cascade_i)));
endmodule

// File: tb/sim_fir_mac_array.sv
module sim_fir_mac_array;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  mode = '0;
  logic        split = 1'b0, dec = 1'b0;
  logic        cwe = 1'b0;
  logic [6:0]  caddr = '0;
  logic [15:0] cdata = '0;
  logic        sen = 1'b0;
  logic [15:0] xa = '0, xb = '0;
  logic [31:0] casc = '0;
  logic        busy, valid;
  logic [31:0] ya, yb;

  fir_mac_array u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .split_i(split), .dec_i(dec),
    .coef_we_i(cwe), .coef_addr_i(caddr), .coef_data_i(cdata),
    .sample_en_i(sen), .x_a_i(xa), .x_b_i(xb), .cascade_i(casc),
    .busy_o(busy), .valid_o(valid), .y_a_o(ya), .y_b_o(yb)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [15:0] cm [128];
  logic [15:0] ha [129];
  logic [15:0] hb [65];
  bit          phase;
  logic [31:0] e_a [1024];
  logic [31:0] e_b [1024];
  int          e_c [1024];
  string       e_t [1024];
  int          wr = 0, rd = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic signed [31:0] red(input logic [15:0] c);
    red = 32'($signed(c[15:4]));
  endfunction

  function automatic int spacing();
    int r = 1 << mode;
    spacing = dec ? ((mode == 0) ? 1 : r / 2) : r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (rd >= wr) chk(1'b0, "R8 unexpected result", ya, 32'h0);
      else begin
        chk(ya == e_a[rd], e_t[rd], ya, e_a[rd]);
        chk(yb == e_b[rd], split ? "R6 filter B" : "R6 B idle", yb, e_b[rd]);
        chk(cyc == e_c[rd], "R8 latency", 32'(cyc), 32'(e_c[rd]));
        rd++;
      end
    end
  end

  task automatic do_reset(input logic [1:0] m, input bit s, input bit d);
    @(negedge clk);
    rst_n = 1'b0; sen = 1'b0; mode = m; split = s; dec = d;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 129; i++) ha[i] = '0;
    for (int i = 0; i < 65; i++) hb[i] = '0;
    for (int i = 0; i < 128; i++) cm[i] = '0;
    phase = 1'b0;
    rd = 0; wr = 0;
  endtask

  task automatic load(input int kind);
    for (int i = 0; i < 128; i++) begin
      logic [15:0] v;
      case (kind)
        0: v = 16'($urandom);
        1: v = 16'h7FF0;
        default: v = (i == 0) ? 16'h002F : (i == 1) ? 16'hFFF8 : 16'h000F;
      endcase
      cwe = 1'b1; caddr = 7'(i); cdata = v; cm[i] = v;
      @(negedge clk);
    end
    cwe = 1'b0;
  endtask

  // drive one accepted sample at a negedge, then wait sp cycles
  task automatic push(input logic [15:0] a, input logic [15:0] b, input logic [31:0] cs,
                      input int sp, input string tag);
    logic signed [31:0] sa, sb;
    int t;
    sen = 1'b1; xa = a; xb = b; casc = cs;
    if (!split) begin
      for (int i = 128; i > 0; i--) ha[i] = ha[i-1];
      ha[0] = a;
    end else begin
      for (int i = 64; i > 0; i--) begin ha[i] = ha[i-1]; hb[i] = hb[i-1]; end
      ha[0] = a; hb[0] = b;
    end
    if (!dec || phase) begin
      sa = cs; sb = '0;
      t = split ? (8 << mode) : (16 << mode);
      for (int i = 0; i < t; i++) begin
        sa = sa + red(cm[i]) * 32'($signed(ha[i]));
        if (split) sb = sb + red(cm[64+i]) * 32'($signed(hb[i]));
      end
      e_a[wr] = sa; e_b[wr] = sb; e_c[wr] = cyc + (1 << mode) + 2; e_t[wr] = tag;
      wr++;
    end
    if (dec) phase = !phase;
    @(negedge clk);
    sen = 1'b0;
    repeat (sp - 1) @(negedge clk);
  endtask

  task automatic burst(input int n, input string tag);
    for (int i = 0; i < n; i++)
      push(16'($urandom), 16'($urandom), $urandom, spacing(), tag);
  endtask

  task automatic drain();
    repeat (20) @(negedge clk);
    chk(rd == wr, "R8 result count", 32'(rd), 32'(wr));
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog", 32'(cyc), 32'h0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset(2'd0, 1'b0, 1'b0);
    chk(valid == 1'b0, "R10 valid after reset", 32'(valid), 32'h0);
    chk(busy == 1'b0, "R10 busy after reset", 32'(busy), 32'h0);
    chk(ya == '0, "R10 y_a after reset", ya, 32'h0);
    chk(yb == '0, "R10 y_b after reset", yb, 32'h0);

    for (int m = 0; m < 4; m++) begin
      do_reset(2'(m), 1'b0, 1'b0);
      load(0);
      burst(40, "R1 single filter with cascade R5");
      drain();
    end

    // R2: a strobe in a busy cycle is ignored
    do_reset(2'd2, 1'b0, 1'b0);
    load(0);
    burst(5, "R1 before ignored strobe");
    for (int i = 0; i < 6; i++) begin
      push(16'($urandom), 16'h0, $urandom, 1, "R2 ignored strobe kept out");
      chk(busy == 1'b1, "R2 busy after accept", 32'(busy), 32'h1);
      sen = 1'b1; xa = 16'h7FFF; casc = 32'hDEAD_BEEF;
      @(negedge clk);
      sen = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R2 busy clears", 32'(busy), 32'h0);
    end
    // R9: reload without reset
    load(0);
    burst(20, "R9 reloaded coefficients");
    drain();

    for (int m = 1; m < 4; m += 2) begin
      do_reset(2'(m), 1'b1, 1'b0);
      load(0);
      burst(40, "R6 split filter A");
      drain();
    end

    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      do_reset(2'(m), 1'b0, 1'b1);
      load(0);
      burst(40, "R7 decimate");
      drain();
    end
    do_reset(2'd2, 1'b1, 1'b1);
    load(0);
    burst(40, "R7 decimate split R6");
    drain();

    // R3: only bits 15:4 count
    do_reset(2'd0, 1'b0, 1'b0);
    load(2);
    push(16'd1000, 16'h0, 32'h0, 1, "R3 truncated coefficient");
    push(16'd0, 16'h0, 32'h0, 1, "R3 truncated coefficient");
    push(16'd0, 16'h0, 32'h0, 1, "R3 truncated coefficient");
    drain();
    chk(e_a[0] == 32'd2000, "R3 expected impulse tap0", e_a[0], 32'd2000);
    chk(e_a[1] == 32'hFFFF_FC18, "R3 expected impulse tap1", e_a[1], 32'hFFFF_FC18);

    // R4: full-scale sums wrap modulo 2^32
    do_reset(2'd3, 1'b0, 1'b0);
    load(1);
    for (int i = 0; i < 20; i++) push(16'h7FFF, 16'h0, 32'h7FFF_FFFF, 8, "R4 wrapping sum");
    drain();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule